// File: doc/BRIEF.md
# Codec Control-Port Write Serializer

This block sends single register writes to audio codecs over a three-wire control port. A write is one 16-bit frame. The frame holds a 2-bit chip address, a write flag that is always 1, a 5-bit register address and an 8-bit data byte. The frame goes out most significant bit first. Every bit takes three timed intervals. In the first the serial clock falls, in the second the data line takes the bit, and in the third the clock rises. One interval lasts `div_i + 1` system clocks.

A chip-select bus of `CS_W` lines identifies the target. The mode input picks one of three behaviours. In direct mode the select line of the indexed chip is held low around the frame. In trigger mode that line stays high during the frame and then gives a one-interval low pulse that commits the write. In address mode the bus carries a configured select code during the frame and a configured idle code afterwards. For the length of a transfer, a set of side flag outputs is forced: the set mask is ORed in and the clear mask is then cleared. A host starts a write with `start_i` and then waits for the one-cycle `done_o` pulse.

Top module: `codec_ctl_ser`

## Requirements
- R1: The frame is `{caddr_i[1:0], 1'b1, reg_addr_i[4:0], wdata_i[7:0]}`, with caddr in bits 15:14 and data in bits 7:0. It is sent from bit 15 down to bit 0, and all fields are captured when the start is accepted.
- R2: Each bit spans three intervals of `div_i+1` clocks. In the first, `sclk_o` goes low. In the second, `sdata_o` takes the bit. In the third, `sclk_o` goes high. While idle, `sclk_o` is high, and `sdata_o` never changes while `sclk_o` is high.
- R3: In direct mode (`mode_i`=0, and also the reserved value 3), line `cs_o[chip_i]` goes low at acceptance. The first clock fall follows one interval later. The line goes high one interval after the last clock rise. The other lines are left unchanged.
- R4: In trigger mode (`mode_i`=1), `cs_o[chip_i]` goes high at acceptance, and the first clock fall happens in the same cycle. One interval after the last clock rise the line goes low for exactly one interval, and then it goes high again.
- R5: In address mode (`mode_i`=2), `cs_o` takes `sel_code_i` at acceptance. The first clock fall follows one interval later. One interval after the last clock rise, `cs_o` takes `idle_code_i`. While idle, `cs_o` keeps its last value.
- R6: A start with `chip_i` >= `NUM_CHIPS` (4) is rejected. Busy and done stay low, and `cs_o`, `sclk_o` and `sdata_o` do not change.
- R7: While busy, `flags_o` = `(flag_base_i | flag_set_i) & ~flag_clr_i`. While idle, `flags_o` = `flag_base_i`.
- R8: One interval after the final select change, `done_o` pulses for one cycle. `busy_o` falls in that same cycle, 50 intervals after acceptance in every mode.
- R9: A start that arrives while busy is ignored, and the transfer in progress completes unchanged.
- R10: After reset, `sclk_o`=1, `sdata_o`=0, `cs_o` is all ones, and `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one write |
| chip_i | input | CHIP_W | Index of the target chip |
| mode_i | input | 2 | Select mode: 0 direct, 1 trigger, 2 address, 3 as direct |
| caddr_i | input | 2 | Chip address field of the frame |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Data byte |
| div_i | input | DIV_W | Interval length minus one, in clocks |
| sel_code_i | input | CS_W | Select bus value used during an address-mode frame |
| idle_code_i | input | CS_W | Select bus value used after an address-mode frame |
| flag_base_i | input | FLAG_W | Flag output value when idle |
| flag_set_i | input | FLAG_W | Flags forced high while busy |
| flag_clr_i | input | FLAG_W | Flags forced low while busy (takes priority) |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| cs_o | output | CS_W | Chip-select bus |
| flags_o | output | FLAG_W | Side flag outputs |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench samples every interval of every frame and compares it with a cycle-exact model. This catches a design that reverses the bit order, puts a different value in the write-flag bit, or swaps the data and clock steps. Trigger mode gets specific attention. It has no lead-in interval and ends with a trailing pulse, so a design that shared the direct-mode timeline would be off by one interval or would never pulse the line. Further checks cover chip indices of 4 or more, which must leave the bus untouched, and a second start issued partway through a frame with changed inputs, which would corrupt the frame if the design reloaded its fields. Interval lengths of one clock and longer values are both exercised, to expose a divider that is off by one.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int FRAME_W = 16;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_TRIGGER = 2'd1,
    MODE_ADDR    = 2'd2,
    MODE_RSVD    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CS_KEEP,
    CS_DROP,
    CS_RAISE,
    CS_LOAD_SEL,
    CS_LOAD_IDLE
  } cs_act_e;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [1:0] caddr,
                                                     input logic [4:0] reg_addr,
                                                     input logic [7:0] wdata);
    return {caddr, 1'b1, reg_addr, wdata};
  endfunction
endpackage

// File: rtl/ccs_interval_timer.sv
module ccs_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ccs_select_drv.sv
module ccs_select_drv
  import ccs_pkg::*;
#(
  parameter int CS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cs_act_e         act_i,
  input  logic [CS_W-1:0] hit_i,
  input  logic [CS_W-1:0] sel_i,
  input  logic [CS_W-1:0] idle_i,
  output logic [CS_W-1:0] cs_o
);
  logic [CS_W-1:0] cs_q, cs_d;

  always_comb begin
    unique case (act_i)
      CS_DROP:      cs_d = cs_q & ~hit_i;
      CS_RAISE:     cs_d = cs_q | hit_i;
      CS_LOAD_SEL:  cs_d = sel_i;
      CS_LOAD_IDLE: cs_d = idle_i;
      default:      cs_d = cs_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '1;
    else         cs_q <= cs_d;
  end

  assign cs_o = cs_q;
endmodule

// File: rtl/codec_ctl_ser.sv
module codec_ctl_ser
  import ccs_pkg::*;
#(
  parameter int CS_W      = 4,
  parameter int NUM_CHIPS = 4,
  parameter int CHIP_W    = 3,
  parameter int FLAG_W    = 4,
  parameter int DIV_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHIP_W-1:0] chip_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        caddr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CS_W-1:0]   sel_code_i,
  input  logic [CS_W-1:0]   idle_code_i,
  input  logic [FLAG_W-1:0] flag_base_i,
  input  logic [FLAG_W-1:0] flag_set_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic [CS_W-1:0]   cs_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(FRAME_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_BIT, S_TRIG, S_HOLD} st_e;

  st_e               st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              sclk_q, sclk_d, sdata_q, sdata_d, done_q, done_d;
  logic [FRAME_W-1:0] frame_q;
  mode_e             mode_q;
  logic [CHIP_W-1:0] chip_q;
  logic [DIV_W-1:0]  div_q;
  logic [CS_W-1:0]   sel_q, idle_q;

  logic              accept, expired, load;
  cs_act_e           cs_act;
  mode_e             mode_in;
  logic [CHIP_W-1:0] chip_cur;
  logic [CS_W-1:0]   hit;

  assign mode_in = mode_e'(mode_i);
  assign accept  = (st_q == S_IDLE) && start_i &&
                   ({1'b0, chip_i} < (CHIP_W+1)'(NUM_CHIPS));
  assign chip_cur = accept ? chip_i : chip_q;

  // one-hot decode of the target chip onto the select lines
  for (genvar g = 0; g < CS_W; g++) begin : g_hit
    assign hit[g] = (chip_cur == CHIP_W'(g));
  end

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    sclk_d  = sclk_q;
    sdata_d = sdata_q;
    cs_act  = CS_KEEP;
    load    = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        load = 1'b1;
        if (mode_in == MODE_TRIGGER) begin
          cs_act = CS_RAISE;
          sclk_d = 1'b0;
          ph_d   = 2'd0;
          idx_d  = TOP_IDX;
          st_d   = S_BIT;
        end else begin
          cs_act = (mode_in == MODE_ADDR) ? CS_LOAD_SEL : CS_DROP;
          st_d   = S_PRE;
        end
      end
      S_PRE: if (expired) begin
        load   = 1'b1;
        sclk_d = 1'b0;
        ph_d   = 2'd0;
        idx_d  = TOP_IDX;
        st_d   = S_BIT;
      end
      S_BIT: if (expired) begin
        load = 1'b1;
        unique case (ph_q)
          2'd0: begin sdata_d = frame_q[idx_q]; ph_d = 2'd1; end
          2'd1: begin sclk_d = 1'b1; ph_d = 2'd2; end
          default: begin
            if (idx_q == '0) begin
              unique case (mode_q)
                MODE_TRIGGER: begin cs_act = CS_DROP; st_d = S_TRIG; end
                MODE_ADDR:    begin cs_act = CS_LOAD_IDLE; st_d = S_HOLD; end
                default:      begin cs_act = CS_RAISE; st_d = S_HOLD; end
              endcase
            end else begin
              idx_d  = idx_q - 1'b1;
              sclk_d = 1'b0;
              ph_d   = 2'd0;
            end
          end
        endcase
      end
      S_TRIG: if (expired) begin
        load   = 1'b1;
        cs_act = CS_RAISE;
        st_d   = S_HOLD;
      end
      S_HOLD: if (expired) begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      sclk_q  <= 1'b1;
      sdata_q <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= '0;
      mode_q  <= MODE_DIRECT;
      chip_q  <= '0;
      div_q   <= '0;
      sel_q   <= '0;
      idle_q  <= '1;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      sclk_q  <= sclk_d;
      sdata_q <= sdata_d;
      done_q  <= done_d;
      if (accept) begin
        frame_q <= build_frame(caddr_i, reg_addr_i, wdata_i);
        mode_q  <= mode_in;
        chip_q  <= chip_i;
        div_q   <= div_i;
        sel_q   <= sel_code_i;
        idle_q  <= idle_code_i;
      end
    end
  end

  ccs_interval_timer #(.W(DIV_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .val_i     (accept ? div_i : div_q),
    .expired_o (expired)
  );

  ccs_select_drv #(.CS_W(CS_W)) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (cs_act),
    .hit_i  (hit),
    .sel_i  (accept ? sel_code_i : sel_q),
    .idle_i (idle_q),
    .cs_o   (cs_o)
  );

  assign busy_o  = (st_q != S_IDLE);
  assign sclk_o  = sclk_q;
  assign sdata_o = sdata_q;
  assign done_o  = done_q;
  assign flags_o = busy_o ? ((flag_base_i | flag_set_i) & ~flag_clr_i) : flag_base_i;
endmodule

// File: rtl/codec_ctl_ser_chk.sv
module codec_ctl_ser_chk #(
  parameter int CS_W      = 4,
  parameter int NUM_CHIPS = 4,
  parameter int CHIP_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CHIP_W-1:0] chip_i,
  input logic              sclk_o,
  input logic              sdata_o,
  input logic [CS_W-1:0]   cs_o,
  input logic              busy_o,
  input logic              done_o
);
  p_idle_sclk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);

  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  p_idle_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cs_o));

  p_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (int'(chip_i) >= NUM_CHIPS)) |=> (!busy_o && $stable(cs_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
endmodule

bind codec_ctl_ser codec_ctl_ser_chk #(
  .CS_W(CS_W), .NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chip_i(chip_i),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .cs_o(cs_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_codec_ctl_ser.sv
module test_codec_ctl_ser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] chip_i = '0;
  logic [1:0] mode_i = '0;
  logic [1:0] caddr_i = '0;
  logic [4:0] reg_addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] div_i = '0;
  logic [3:0] sel_code_i = '0, idle_code_i = '1;
  logic [3:0] flag_base_i = '0, flag_set_i = '0, flag_clr_i = '0;
  logic       sclk_o, sdata_o, busy_o, done_o;
  logic [3:0] cs_o, flags_o;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_cs = 4'hF;
  logic       m_sdata = 1'b0, m_sclk = 1'b1;

  always #5 clk_i = ~clk_i;

  codec_ctl_ser i_codec_ctl_ser (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [1:0] ca, input logic [4:0] ra,
                                            input logic [7:0] wd);
    return {ca, 1'b1, ra, wd};
  endfunction

  task automatic run_xfer(input logic [1:0] md, input logic [2:0] ch, input logic [1:0] ca,
                          input logic [4:0] ra, input logic [7:0] wd, input logic [7:0] dv,
                          input logic [3:0] sc, input logic [3:0] ic, input logic [3:0] fb,
                          input logic [3:0] fs, input logic [3:0] fc, input bit inject);
    logic [15:0] fr;
    int t, p, j;
    bit trig, adr;
    string cs_tag;
    fr = exp_frame(ca, ra, wd);
    t = int'(dv) + 1;
    trig = (md == 2'd1);
    adr = (md == 2'd2);
    p = trig ? 0 : 1;
    cs_tag = trig ? "R4 cs" : (adr ? "R5 cs" : "R3 cs");
    mode_i = md; chip_i = ch; caddr_i = ca; reg_addr_i = ra; wdata_i = wd; div_i = dv;
    sel_code_i = sc; idle_code_i = ic; flag_base_i = fb; flag_set_i = fs; flag_clr_i = fc;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k <= 50; k++) begin
      if (k > 0) begin
        for (int c = 0; c < t; c++) begin
          @(negedge clk_i);
          start_i = 1'b0;
        end
      end
      if (k == 0) begin
        if (trig) m_cs[ch] = 1'b1;
        else if (adr) m_cs = sc;
        else m_cs[ch] = 1'b0;
      end
      j = k - p;
      if (k >= p && j < 48) begin
        case (j % 3)
          0: m_sclk = 1'b0;
          1: m_sdata = fr[15 - j/3];
          default: m_sclk = 1'b1;
        endcase
      end
      if (j == 48) begin
        if (trig) m_cs[ch] = 1'b0;
        else if (adr) m_cs = ic;
        else m_cs[ch] = 1'b1;
      end
      if (j == 49 && trig) m_cs[ch] = 1'b1;
      check("R2 sclk", 32'(sclk_o), 32'(m_sclk));
      check("R1 sdata", 32'(sdata_o), 32'(m_sdata));
      check(cs_tag, 32'(cs_o), 32'(m_cs));
      check("R7 flags", 32'(flags_o), 32'((k < 50) ? ((fb | fs) & ~fc) : fb));
      check("R8 busy", 32'(busy_o), 32'(k < 50));
      check("R8 done", 32'(done_o), 32'(k == 50));
      if (inject && k == 5) begin
        // R9: a second start while busy with different fields
        start_i = 1'b1;
        wdata_i = ~wd;
        reg_addr_i = ~ra;
        chip_i = 3'd0;
        mode_i = md + 2'd1;
      end
    end
    @(negedge clk_i);
    check("R8 done single", 32'(done_o), 32'd0);
    check("R9 idle after", 32'(busy_o), 32'd0);
  endtask

  task automatic try_reject(input logic [2:0] ch);
    chip_i = ch;
    mode_i = 2'($urandom % 4);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R6 busy", 32'(busy_o), 32'd0);
    check("R6 done", 32'(done_o), 32'd0);
    check("R6 cs", 32'(cs_o), 32'(m_cs));
    check("R6 sclk", 32'(sclk_o), 32'd1);
    check("R6 sdata", 32'(sdata_o), 32'(m_sdata));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 sclk", 32'(sclk_o), 32'd1);
    check("R10 sdata", 32'(sdata_o), 32'd0);
    check("R10 cs", 32'(cs_o), 32'hF);
    check("R10 busy", 32'(busy_o), 32'd0);
    check("R10 done", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_xfer(2'd0, 3'd2, 2'b10, 5'h15, 8'hA5, 8'd0, 4'h0, 4'hF, 4'h0, 4'h3, 4'h0, 0);
    run_xfer(2'd1, 3'd1, 2'b01, 5'h0A, 8'h5A, 8'd2, 4'h0, 4'hF, 4'h8, 4'h1, 4'h8, 0);
    run_xfer(2'd2, 3'd0, 2'b11, 5'h1F, 8'hFF, 8'd1, 4'h6, 4'h9, 4'h5, 4'h2, 4'h1, 0);
    run_xfer(2'd3, 3'd3, 2'b00, 5'h00, 8'h00, 8'd0, 4'h0, 4'h0, 4'hF, 4'h0, 4'hF, 0);
    run_xfer(2'd1, 3'd3, 2'b10, 5'h11, 8'h81, 8'd0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 1);
    try_reject(3'd4);
    try_reject(3'd7);

    for (int n = 0; n < 24; n++) begin
      run_xfer(2'($urandom % 4), 3'($urandom % 4), 2'($urandom), 5'($urandom),
               8'($urandom), 8'($urandom % 4), 4'($urandom), 4'($urandom),
               4'($urandom), 4'($urandom), 4'($urandom), ($urandom % 3) == 0);
      if (n % 6 == 5) try_reject(3'(4 + $urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule